// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Responder

This block is a synthesizable, device-side model of a serial flash read engine. It oversamples chip select, the serial clock and the IO0 line with a fast system clock. It decodes the dual-output fast read command and captures a 24-bit byte address. It then lets eight dummy clocks pass. After that it returns bytes from a small internal array on two lines at once, IO1 and IO0. Each line has its own output-enable, so the surrounding logic can build the tri-state pads.

A transaction opens when chip select falls and closes when it rises. If the first byte is not the expected command, the rest of the transaction is ignored. The array size is a parameter and must be a power of two. A plain synchronous write port loads the array before reads are issued.

Sampling follows the serial clock's rising edges. Outputs change only on its falling edges. Because of this, both SPI mode 0 (clock idle low) and SPI mode 3 (clock idle high) are served.

Top module: `dual_read_responder`

## Requirements
- R1: The command byte is the first eight bits sampled on IO0 at rising SCK edges after chip select falls, MSB first; only the value 0x3B starts a read.
- R2: The next 24 rising edges shift in a byte address MSB first on IO0; only its low log2(DEPTH) bits select the array byte, and the upper bits are ignored.
- R3: The following eight rising edges are dummy clocks, and the value on IO0 during them has no effect on the data returned.
- R4: Both output-enables assert together, one system clock after the first SCK falling edge that follows the 40th rising edge. Before that edge they are low.
- R5: Each byte is sent over four SCK cycles as the pairs (bit7,bit6), (bit5,bit4), (bit3,bit2), (bit1,bit0) on (IO1,IO0). The pair changes only on SCK falling edges.
- R6: After every four pairs the address advances by one, and bytes keep flowing for as long as chip select stays low.
- R7: The address wraps from DEPTH-1 to 0.
- R8: When chip select is high, both output-enables are low from the next system clock onward. A transaction cut short at any point leaves the following transaction unaffected.
- R9: After any command byte other than 0x3B, both output-enables stay low until chip select rises, even through what would be the data phase.
- R10: With wr_en high, wr_data is written to array location wr_addr on the system clock edge, and it is returned by later reads of that location.
- R11: Reads behave identically whether SCK idles low or high while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| io0_in | input | 1 | Value sensed on the IO0 line |
| io0_out | output | 1 | Value driven on IO0 during data (even bits) |
| io0_oe | output | 1 | Output-enable for IO0 |
| io1_out | output | 1 | Value driven on IO1 during data (odd bits) |
| io1_oe | output | 1 | Output-enable for IO1 |
| wr_en | input | 1 | Array preload strobe |
| wr_addr | input | AW | Array preload address, AW = log2(DEPTH) |
| wr_data | input | 8 | Array preload byte |

## Verification
The design sees an SCK edge on the first system clock after the edge happens, and it updates its outputs on that same clock. The bench therefore holds each SCK level for four system clocks. It reads IO1, IO0 and the enables just before it raises SCK, which is three clocks after the design has reacted to the preceding falling edge. The same timing is used to check the enables one falling edge after the 40th rising edge, and again two clocks after chip select rises. Every start address of a 16-byte array is read across the wrap point, with random bits on IO0 during the dummy clocks. The expected byte and pair come from the bench's own copy of the preload values.

// File: rtl/dual_read_responder.sv
module dual_read_responder #(
  parameter int DEPTH  = 256,
  parameter logic [7:0] OPCODE = 8'h3B,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          io0_in,
  output logic          io0_out,
  output logic          io0_oe,
  output logic          io1_out,
  output logic          io1_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data
);

  localparam logic [5:0] DATA_START = 6'd40;

  logic [7:0]    mem [DEPTH];
  logic          sck_q;
  logic [5:0]    cnt;
  logic          bad;
  logic          oe;
  logic [1:0]    pidx;
  logic [23:0]   shreg;
  logic [AW-1:0] addr;
  logic [1:0]    pair;
  logic [7:0]    byte_q;

  wire rise   = sck & ~sck_q;
  wire fall   = ~sck & sck_q;
  wire in_data = (cnt == DATA_START) && !bad;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cnt    <= '0;
      bad    <= 1'b0;
      oe     <= 1'b0;
      pidx   <= '0;
      shreg  <= '0;
      addr   <= '0;
      pair   <= '0;
      byte_q <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        cnt  <= '0;
        bad  <= 1'b0;
        oe   <= 1'b0;
        pidx <= '0;
      end else begin
        if (rise && cnt != DATA_START) begin
          cnt   <= cnt + 6'd1;
          shreg <= {shreg[22:0], io0_in};
          if (cnt == 6'd7 && {shreg[6:0], io0_in} != OPCODE) bad <= 1'b1;
          if (cnt == 6'd31) addr <= {shreg[AW-2:0], io0_in};
        end
        if (fall && in_data) begin
          oe   <= 1'b1;
          pidx <= pidx + 2'd1;
          if (pidx == 2'd0) begin
            pair   <= mem[addr][7:6];
            byte_q <= {mem[addr][5:0], 2'b00};
            addr   <= addr + 1'b1;
          end else begin
            pair   <= byte_q[7:6];
            byte_q <= {byte_q[5:0], 2'b00};
          end
        end
      end
    end
  end

  assign io1_out = pair[1];
  assign io0_out = pair[0];
  assign io0_oe  = oe;
  assign io1_oe  = oe;

  AST_DRIVE_AFTER_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> (cnt == DATA_START)); // R4
  AST_SILENT_ON_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> !io0_oe && !io1_oe); // R9
  AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !io0_oe && !io1_oe); // R8
  AST_PAIR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable({io1_out, io0_out})); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && in_data && !cs_n && pidx == 2'd0) |=> addr == $past(addr) + 1'b1); // R6

endmodule

// File: tb/test_dual_read_responder.sv
module test_dual_read_responder;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic io0_in = 1'b0;
  logic io0_out, io0_oe, io1_out, io1_oe;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_read_responder #(.DEPTH(DEPTH)) i_dual_read_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io0_in(io0_in),
    .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] model(int a);
    return 8'((a % DEPTH) * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    sck = 1'b0;
    io0_in = b;
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic finish_txn(bit idle_hi);
    cs_n = 1'b1;
    sck = idle_hi;
    wait_clk(2);
    chk(!io0_oe && !io1_oe, "R8", {io1_oe, io0_oe}, 0);
    wait_clk(2);
  endtask

  task automatic read_txn(logic [7:0] op, logic [23:0] a, int nbytes, bit idle_hi);
    sck = idle_hi;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(2);
    for (int i = 7; i >= 0; i--) send_bit(op[i]);
    for (int i = 23; i >= 0; i--) send_bit(a[i]);
    chk(!io0_oe && !io1_oe, "R4 before dummy", {io1_oe, io0_oe}, 0);
    for (int i = 0; i < 8; i++) send_bit(1'($urandom)); // R3 random dummy bits
    chk(!io0_oe, "R4 after 40th rise", io0_oe, 0);
    io0_in = 1'b0;
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] exp_byte;
      exp_byte = model(int'(a[AW-1:0]) + b); // R2 R6 R7 R10
      for (int p = 0; p < 4; p++) begin
        sck = 1'b0;
        wait_clk(HALF);
        if (op == 8'h3B) begin
          chk(io0_oe && io1_oe, "R4", {io1_oe, io0_oe}, 3);
          chk({io1_out, io0_out} == exp_byte[7-2*p -: 2], "R5 R6 R7",
              {io1_out, io0_out}, exp_byte[7-2*p -: 2]);
        end else begin
          chk(!io0_oe && !io1_oe, "R9", {io1_oe, io0_oe}, 0);
        end
        sck = 1'b1;
        wait_clk(HALF);
      end
    end
    finish_txn(idle_hi);
  endtask

  initial begin
    wait_clk(3);
    chk(!io0_oe && !io1_oe, "reset", {io1_oe, io0_oe}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin // R10 preload
      wr_en = 1'b1;
      wr_addr = AW'(i);
      wr_data = model(i);
      wait_clk(1);
    end
    wr_en = 1'b0;
    wait_clk(2);
    for (int s = 0; s < DEPTH; s++)
      read_txn(8'h3B, {8'hA5, 12'h3C0, 4'(s)}, 18, 1'b0); // R1 R2 R3 R6 R7
    read_txn(8'h3B, 24'hFFFFF9, 4, 1'b1); // R11
    read_txn(8'h3B, 24'h000003, 3, 1'b1); // R11
    read_txn(8'h3A, 24'h000000, 3, 1'b0); // R9
    read_txn(8'hBB, 24'h000005, 2, 1'b1); // R9
    read_txn(8'h03, 24'h000005, 2, 1'b0); // R1 R9
    sck = 1'b0;
    cs_n = 1'b0;
    wait_clk(2);
    for (int i = 0; i < 12; i++) send_bit(i[0]);
    finish_txn(1'b0); // R8 abort mid-address
    read_txn(8'h3B, 24'h00000E, 4, 1'b0); // R8 recovery
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule